// File: doc/BRIEF.md
# Ethernet PAUSE Frame Detector

This block watches the bytes of a received Ethernet frame and decides whether the frame is a MAC control PAUSE request aimed at this station. It checks the destination address, the length/type field and the opcode as each byte goes past. It also keeps the 16-bit pause duration carried after the opcode. When the last byte arrives, the receive status is applied. If the frame is good and flow control is allowed, the block raises a one-cycle detect pulse and presents the captured duration. A transmit pause timer downstream can start counting from that pulse.

The receive path delivers one byte per accepted cycle. `rx_valid` qualifies each byte, `rx_sof` marks the first byte of a frame and `rx_eof` marks its last. `rx_good` carries the frame status and is read on the same beat as `rx_eof`. The preamble and SFD are already stripped. The frame check sequence is judged upstream and folded into `rx_good`.

Top module: `pause_frame_detector`

## Requirements
- R1: A detection happens only if `fdx_en` and `fc_en` are both 1 on the end-of-frame beat; if either is 0, `pause_det` stays 0.
- R2: Frame bytes 0..5 (byte 0 first, most significant byte of the address first) must equal either 01-80-C2-00-00-01 or `station_addr`, with byte 0 compared against `station_addr[47:40]`.
- R3: Bytes 6..11 (source address) never affect the outcome.
- R4: Bytes 12 and 13 must be 0x88 and 0x08.
- R5: Bytes 14 and 15 must be 0x00 and 0x01.
- R6: Bytes 16 (high) and 17 (low) form the duration. On a detection it appears on `pause_quanta`. `pause_quanta` holds its value until the next detection, and every value from 0x0000 to 0xFFFF is passed unchanged.
- R7: A frame whose `rx_good` is 0 on its end-of-frame beat is never detected.
- R8: A frame of fewer than 18 bytes is never detected. A frame of 18 or more bytes may be detected, and trailing bytes are ignored.
- R9: A byte with `rx_sof` = 1 starts a new frame and discards any partial match, even if the previous frame had no end marker.
- R10: `pause_det` rises exactly one clock after the accepted end-of-frame beat and lasts one cycle. After reset, `pause_det` = 0 and `pause_quanta` = 0.
- R11: Cycles with `rx_valid` = 0 are ignored. Valid bytes that come between an end-of-frame beat and the next start-of-frame beat are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_good | input | 1 | Frame status, read with `rx_eof` |
| station_addr | input | 48 | Station physical address |
| fdx_en | input | 1 | Full-duplex mode |
| fc_en | input | 1 | Flow-control enable |
| pause_det | output | 1 | One-cycle PAUSE detection pulse |
| pause_quanta | output | 16 | Captured pause duration |

## Verification
The bound checker tests every cycle that a pulse follows an accepted end-of-frame beat, and that the enables and the good status were present on that beat. It also tests that the pulse never lasts two cycles, that the duration output moves only with a pulse, and that the frame had at least 18 bytes. Which byte values must match, the choice between the two addresses, the value of the captured duration and recovery from aborted frames can only be shown by the bench. Its scenarios replay frames through a queue-based model and compare both outputs on every clock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam logic [47:0] PFD_CTRL_ADDR = 48'h0180_C200_0001;
  localparam logic [15:0] PFD_CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PFD_PAUSE_OP  = 16'h0001;
  localparam int          PFD_DA_BYTES  = 6;
  localparam int          PFD_TYPE_POS  = 12;
  localparam int          PFD_OP_POS    = 14;
  localparam int          PFD_DUR_POS   = 16;
  localparam int          PFD_MIN_LEN   = 18;
endpackage

// File: rtl/pfd_byte_tracker.sv
module pfd_byte_tracker #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  output logic             byte_take,
  output logic [CNT_W-1:0] byte_pos,
  output logic             frame_end
);
  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic             in_frame;
  logic [CNT_W-1:0] cnt;

  // a byte belongs to a frame if it opens one or arrives inside one
  assign byte_take = rx_valid & (rx_sof | in_frame);
  assign byte_pos  = rx_sof ? '0 : cnt;
  assign frame_end = byte_take & rx_eof;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      cnt      <= '0;
    end else if (byte_take) begin
      in_frame <= ~rx_eof;
      cnt      <= (byte_pos == POS_MAX) ? POS_MAX : byte_pos + 1'b1;
    end
  end
endmodule

// File: rtl/pfd_field_match.sv
module pfd_field_match
  import pfd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_take,
  input  logic             rx_sof,
  input  logic [CNT_W-1:0] byte_pos,
  input  logic [7:0]       rx_data,
  input  logic [47:0]      station_addr,
  output logic             hdr_ok_nx,
  output logic             len_ok_nx
);
  logic [PFD_DA_BYTES-1:0] da_lane, ctl_eq, stn_eq;
  logic [1:0]              ty_lane, ty_eq, op_lane, op_eq;

  // per-position comparators, one lane per header byte
  for (genvar i = 0; i < PFD_DA_BYTES; i++) begin : g_da
    assign da_lane[i] = (byte_pos == CNT_W'(i));
    assign ctl_eq[i]  = (rx_data == PFD_CTRL_ADDR[8*(PFD_DA_BYTES-1-i) +: 8]);
    assign stn_eq[i]  = (rx_data == station_addr[8*(PFD_DA_BYTES-1-i) +: 8]);
  end

  for (genvar j = 0; j < 2; j++) begin : g_two
    assign ty_lane[j] = (byte_pos == CNT_W'(PFD_TYPE_POS + j));
    assign ty_eq[j]   = (rx_data == PFD_CTRL_TYPE[8*(1-j) +: 8]);
    assign op_lane[j] = (byte_pos == CNT_W'(PFD_OP_POS + j));
    assign op_eq[j]   = (rx_data == PFD_PAUSE_OP[8*(1-j) +: 8]);
  end

  logic ctl_miss, stn_miss, ty_miss, op_miss, len_hit;
  assign ctl_miss = |(da_lane & ~ctl_eq);
  assign stn_miss = |(da_lane & ~stn_eq);
  assign ty_miss  = |(ty_lane & ~ty_eq);
  assign op_miss  = |(op_lane & ~op_eq);
  assign len_hit  = (byte_pos >= CNT_W'(PFD_MIN_LEN - 1));

  logic ctl_ok, stn_ok, ty_ok, op_ok, len_ok;
  logic ctl_nx, stn_nx, ty_nx, op_nx;

  always_comb begin
    // a start byte begins from a clean, all-matching state
    ctl_nx    = rx_sof | ctl_ok;
    stn_nx    = rx_sof | stn_ok;
    ty_nx     = rx_sof | ty_ok;
    op_nx     = rx_sof | op_ok;
    len_ok_nx = ~rx_sof & len_ok;
    if (byte_take) begin
      ctl_nx    = ctl_nx & ~ctl_miss;
      stn_nx    = stn_nx & ~stn_miss;
      ty_nx     = ty_nx & ~ty_miss;
      op_nx     = op_nx & ~op_miss;
      len_ok_nx = len_ok_nx | len_hit;
    end
    hdr_ok_nx = (ctl_nx | stn_nx) & ty_nx & op_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_ok <= 1'b0;
      stn_ok <= 1'b0;
      ty_ok  <= 1'b0;
      op_ok  <= 1'b0;
      len_ok <= 1'b0;
    end else if (byte_take) begin
      ctl_ok <= ctl_nx;
      stn_ok <= stn_nx;
      ty_ok  <= ty_nx;
      op_ok  <= op_nx;
      len_ok <= len_ok_nx;
    end
  end
endmodule

// File: rtl/pfd_quanta_capture.sv
module pfd_quanta_capture
  import pfd_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_take,
  input  logic [CNT_W-1:0] byte_pos,
  input  logic [7:0]       rx_data,
  output logic [DUR_W-1:0] dur_nx
);
  localparam int DUR_BYTES = DUR_W / 8;

  logic [DUR_W-1:0] dur_r;

  always_comb begin
    dur_nx = dur_r;
    for (int k = 0; k < DUR_BYTES; k++) begin
      if (byte_take && byte_pos == CNT_W'(PFD_DUR_POS + k))
        dur_nx[8*(DUR_BYTES-1-k) +: 8] = rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dur_r <= '0;
    else     dur_r <= dur_nx;
  end
endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector #(
  parameter int CNT_W = 5,
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  input  logic             rx_good,
  input  logic [47:0]      station_addr,
  input  logic             fdx_en,
  input  logic             fc_en,
  output logic             pause_det,
  output logic [DUR_W-1:0] pause_quanta
);
  logic             byte_take, frame_end, hdr_ok_nx, len_ok_nx;
  logic [CNT_W-1:0] byte_pos;
  logic [DUR_W-1:0] dur_nx;
  logic             hit;

  pfd_byte_tracker #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .byte_take(byte_take), .byte_pos(byte_pos),
    .frame_end(frame_end)
  );

  pfd_field_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .byte_take(byte_take), .rx_sof(rx_sof),
    .byte_pos(byte_pos), .rx_data(rx_data), .station_addr(station_addr),
    .hdr_ok_nx(hdr_ok_nx), .len_ok_nx(len_ok_nx)
  );

  pfd_quanta_capture #(.CNT_W(CNT_W), .DUR_W(DUR_W)) u_dur (
    .clk(clk), .rst(rst), .byte_take(byte_take), .byte_pos(byte_pos),
    .rx_data(rx_data), .dur_nx(dur_nx)
  );

  assign hit = frame_end & rx_good & fdx_en & fc_en & hdr_ok_nx & len_ok_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_det    <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_det <= hit;
      if (hit) pause_quanta <= dur_nx;
    end
  end
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_sof,
  input logic             rx_eof,
  input logic             rx_good,
  input logic             fdx_en,
  input logic             fc_en,
  input logic             pause_det,
  input logic [DUR_W-1:0] pause_quanta
);
  logic       c_in;
  logic [7:0] c_cnt;
  logic       c_long;
  logic       c_take;
  logic [7:0] c_pos;

  assign c_take = rx_valid & (rx_sof | c_in);
  assign c_pos  = rx_sof ? 8'd0 : c_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_in   <= 1'b0;
      c_cnt  <= '0;
      c_long <= 1'b0;
    end else begin
      c_long <= c_take & rx_eof & (c_pos >= 8'd17);
      if (c_take) begin
        c_in  <= ~rx_eof;
        c_cnt <= (c_pos == 8'hFF) ? 8'hFF : c_pos + 8'd1;
      end
    end
  end

  AST_DET_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    pause_det |-> $past(fdx_en & fc_en)); // R1
  AST_DET_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
    pause_det |-> $past(rx_good)); // R7
  AST_DET_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    pause_det |-> $past(rx_valid & rx_eof)); // R10
  AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pause_det |=> !pause_det); // R10
  AST_QUANTA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pause_det |-> $stable(pause_quanta)); // R6
  AST_DET_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
    pause_det |-> c_long); // R8
endmodule

bind pause_frame_detector pfd_checker #(.DUR_W(DUR_W)) u_pfd_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
  .rx_eof(rx_eof), .rx_good(rx_good), .fdx_en(fdx_en), .fc_en(fc_en),
  .pause_det(pause_det), .pause_quanta(pause_quanta)
);

// File: tb/test_pause_frame_detector.sv
`timescale 1ns/1ps
module test_pause_frame_detector;
  typedef logic [7:0] byte_q_t[$];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [47:0] station_addr = 48'h02AB_CDEF_1234;
  logic        fdx_en = 1'b1, fc_en = 1'b1;
  logic        pause_det;
  logic [15:0] pause_quanta;

  always #2.5 clk = ~clk;

  pause_frame_detector i_pause_frame_detector (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .rx_good(rx_good),
    .station_addr(station_addr), .fdx_en(fdx_en), .fc_en(fc_en),
    .pause_det(pause_det), .pause_quanta(pause_quanta)
  );

  int    n_cmp = 0, n_bad = 0;
  string tag = "R10";
  bit    done = 1'b0;

  localparam logic [47:0] CTL_DA = 48'h0180_C200_0001;
  localparam logic [47:0] SA     = 48'h00AA_BBCC_DDEE;

  // ---------------- behavioural reference model ----------------
  byte_q_t     mq;
  bit          m_in = 1'b0, m_take;
  bit          exp_det = 1'b0;
  logic [15:0] exp_q = '0;

  function automatic bit is_pause(byte_q_t q, logic [47:0] stn);
    logic [47:0] da;
    if (q.size() < 18) return 1'b0;
    da = {q[0], q[1], q[2], q[3], q[4], q[5]};
    if (da != 48'h0180_C200_0001 && da != stn) return 1'b0;
    if ({q[12], q[13]} != 16'h8808) return 1'b0;
    if ({q[14], q[15]} != 16'h0001) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_det = 1'b0; exp_q = '0; m_in = 1'b0; mq.delete();
    end else begin
      exp_det = 1'b0;
      m_take = rx_valid && (rx_sof || m_in);
      if (m_take) begin
        if (rx_sof) mq.delete();
        mq.push_back(rx_data);
        m_in = !rx_eof;
        if (rx_eof && rx_good && fdx_en && fc_en && is_pause(mq, station_addr)) begin
          exp_det = 1'b1;
          exp_q   = {mq[16], mq[17]};
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp++;
      if (pause_det !== exp_det || pause_quanta !== exp_q) begin
        n_bad++;
        $display("FAIL %s: det=%0b quanta=%h expected det=%0b quanta=%h",
                 tag, pause_det, pause_quanta, exp_det, exp_q);
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic byte_q_t mk(logic [47:0] da, logic [47:0] sa,
                                 logic [15:0] ty, logic [15:0] op,
                                 logic [15:0] du, int total);
    byte_q_t q;
    for (int i = 5; i >= 0; i--) q.push_back(da[8*i +: 8]);
    for (int i = 5; i >= 0; i--) q.push_back(sa[8*i +: 8]);
    q.push_back(ty[15:8]); q.push_back(ty[7:0]);
    q.push_back(op[15:8]); q.push_back(op[7:0]);
    q.push_back(du[15:8]); q.push_back(du[7:0]);
    while (q.size() < total) q.push_back(8'h00);
    while (q.size() > total) void'(q.pop_back());
    return q;
  endfunction

  task automatic idle(int n);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(byte_q_t q, bit good, bit gaps, bit with_eof);
    for (int i = 0; i < q.size(); i++) begin
      if (gaps && (i % 3 == 1)) idle(1);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = with_eof && (i == q.size() - 1);
      rx_good  = good;
      rx_data  = q[i];
      @(negedge clk);
    end
    idle(3);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    n_cmp++; // R10 reset state
    if (pause_det !== 1'b0 || pause_quanta !== 16'h0000) begin
      n_bad++;
      $display("FAIL R10: det=%0b quanta=%h expected det=0 quanta=0000", pause_det, pause_quanta);
    end

    tag = "R2"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h1234, 60), 1, 0, 1);
    tag = "R2"; send(mk(station_addr, SA, 16'h8808, 16'h0001, 16'h00FF, 60), 1, 0, 1);
    tag = "R2"; send(mk(48'h0180_C200_0002, SA, 16'h8808, 16'h0001, 16'h5555, 60), 1, 0, 1);
    tag = "R2"; send(mk(48'h02AB_CDEF_1235, SA, 16'h8808, 16'h0001, 16'h5555, 60), 1, 0, 1);
    tag = "R3"; send(mk(CTL_DA, 48'hFFFF_FFFF_FFFF, 16'h8808, 16'h0001, 16'h0A0B, 60), 1, 0, 1);
    tag = "R4"; send(mk(CTL_DA, SA, 16'h8809, 16'h0001, 16'h7777, 60), 1, 0, 1);
    tag = "R4"; send(mk(CTL_DA, SA, 16'h0808, 16'h0001, 16'h7777, 60), 1, 0, 1);
    tag = "R5"; send(mk(CTL_DA, SA, 16'h8808, 16'h0101, 16'h7777, 60), 1, 0, 1);
    tag = "R5"; send(mk(CTL_DA, SA, 16'h8808, 16'h0000, 16'h7777, 60), 1, 0, 1);
    tag = "R6"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h0000, 60), 1, 0, 1);
    tag = "R6"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'hFFFF, 60), 1, 0, 1);
    tag = "R7"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h4321, 60), 0, 0, 1);
    tag = "R1"; fdx_en = 1'b0;
    send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h2222, 60), 1, 0, 1);
    fdx_en = 1'b1; fc_en = 1'b0;
    send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h3333, 60), 1, 0, 1);
    fc_en = 1'b1;
    tag = "R8"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h6666, 17), 1, 0, 1);
    tag = "R8"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h6667, 18), 1, 0, 1);
    tag = "R8"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h6668, 40), 1, 0, 1);
    tag = "R9"; send(mk(SA, SA, 16'h0800, 16'h0000, 16'h0000, 10), 1, 0, 0);
    send(mk(station_addr, SA, 16'h8808, 16'h0001, 16'h9999, 60), 1, 0, 1);
    tag = "R9"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'hAAAA, 16), 1, 0, 0);
    send(mk(CTL_DA, SA, 16'h0800, 16'h0001, 16'hAAAA, 60), 1, 0, 1);
    tag = "R11"; send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'hBEEF, 64), 1, 1, 1);
    tag = "R11";
    for (int k = 0; k < 20; k++) begin
      rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (k == 19); rx_good = 1'b1;
      rx_data = mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'hC0DE, 20)[k];
      @(negedge clk);
    end
    idle(3);
    tag = "R10";
    send(mk(CTL_DA, SA, 16'h8808, 16'h0001, 16'h1111, 18), 1, 0, 1);
    send(mk(station_addr, SA, 16'h8808, 16'h0001, 16'h2222, 18), 1, 0, 1);
    idle(5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule